// File: doc/BRIEF.md
# Multi-Window Mailbox Message Sequencer

This engine moves a message of any byte length through a group of `W` adjacent mailbox channel windows, and on the far side collects such a message back into words. It acts as a master on a simple register bus that reaches each window's status, set, clear and mask registers. On the sending side it fetches words from an external word buffer, cuts the message into rounds of at most `W` words, and writes every round in descending word order. The lowest message word of a round therefore lands in the top window of the group, and that write always comes last. Since only the top window is unmasked at the receiver, that last write is the one that raises the interrupt.

Before each round the engine polls the top window's status until it reads zero, which means the receiver has drained the previous round. A programmable limit bounds the number of busy reads. A round whose leading word would go out as zero is refused, because a zero write would never wake the receiver. On the receiving side it reads each window from the bottom up and hands the value out at the mirrored word index, then clears the window with all-ones, so the top window is cleared last. A setup operation masks every window of the group at the receiver except the top one.

Top module: `msg_window_seq`

## Requirements
- R1: After reset the engine is idle: `busy`, `done`, `err` and `bus_req` are all low, and while idle it makes no bus request.
- R2: In every round, word i of that round (buffer word `ptr+i`) is written to the set register (`bus_reg`=1) of window `BASE+W-1-i`. Words go out from the highest i down to 0, so the top window is written last.
- R3: A round carries min(remaining bytes, 4·W) bytes. Word positions at or past that byte count get no write at all.
- R4: When a round's byte count is not a multiple of four, its last word is sent with only the low (count mod 4) bytes kept and the upper bytes zero.
- R5: If the first word of a round, as it would be sent, is zero, the transfer stops before any bus access for that round and ends with `err`.
- R6: Before writing each round, the engine reads the status register (`bus_reg`=0) of window `BASE+W-1` until it returns zero. No write of the round happens while it reads non-zero. The engine issues no bus read of any other register.
- R7: If the status poll returns non-zero `max(cfg_poll_limit,1)` times in a row, the transfer ends with `err`.
- R8: After each round the buffer pointer advances by W. The transfer ends with `done` once the remaining byte count reaches zero. A length of zero ends at once with no bus access.
- R9: On receive, windows `BASE+0` to `BASE+W-1` are read in ascending order. The value of window `BASE+i` is output on `rx_data` with `rx_idx`=W-1-i while `rx_we` is high. Right after each read, the same window's clear register (`bus_reg`=2) is written with all-ones.
- R10: Setup writes all-ones to the mask-set register (`bus_reg`=3) of windows `BASE` to `BASE+W-2`, then all-ones to the mask-clear register (`bus_reg`=4) of window `BASE+W-1`.
- R11: A start of any kind that arrives while `busy` is high is ignored. If starts coincide while idle, setup wins over transmit, and transmit wins over receive.
- R12: `done` is a one-cycle pulse at the end of every operation. `err` is a one-cycle pulse that only comes together with `done`.
- R13: Once raised, `bus_req` holds with stable address, register select, direction and write data until `bus_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_poll_limit | input | PLW | Allowed number of busy status reads per round |
| setup_start | input | 1 | Start receiver mask setup |
| tx_start | input | 1 | Start sending a message |
| tx_len | input | LENW | Message length in bytes, sampled with `tx_start` |
| rx_start | input | 1 | Start collecting a message |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| err | output | 1 | One-cycle failure pulse, with `done` |
| buf_addr | output | BAW | Word address into the message buffer |
| buf_data | input | 32 | Buffer word at `buf_addr` (same-cycle read) |
| rx_we | output | 1 | Received word valid |
| rx_idx | output | IW | Word index of the received word |
| rx_data | output | 32 | Received word |
| bus_req | output | 1 | Register bus request |
| bus_we | output | 1 | 1 write, 0 read |
| bus_reg | output | 3 | Register select: 0 status, 1 set, 2 clear, 3 mask-set, 4 mask-clear |
| bus_win | output | AW | Window index |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | Access accepted at this clock edge |
| bus_rdata | input | 32 | Read data, valid with `bus_ack` |

## Verification
The assertions check on every cycle that the bus request holds steady until it is acknowledged, that reads only touch status registers, and that addresses stay inside the group. They also check that clears carry all-ones, that received words appear only on an accepted read, that the end pulses are one cycle wide with `err` only beside `done`, and that the idle engine stays off the bus. The ordering of writes within and across rounds, the byte masking of short words, the refusal of a zero leading word, the bounded poll, the mirrored receive indices and the ignoring of starts during a transfer can only be shown by the bench's scenarios, which compare a log of every accepted bus access against sequences worked out from the requirements.

// File: rtl/msgseq_pkg.sv
package msgseq_pkg;

  typedef enum logic [2:0] {
    REG_STAT = 3'd0,
    REG_SET  = 3'd1,
    REG_CLR  = 3'd2,
    REG_MSET = 3'd3,
    REG_MCLR = 3'd4
  } win_reg_e;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_SETUP = 3'd1,
    S_TCHK  = 3'd2,
    S_TPOLL = 3'd3,
    S_TWR   = 3'd4,
    S_RRD   = 3'd5,
    S_RCLR  = 3'd6
  } seq_state_e;

  // Keep the low n bytes of a word; n == 0 means the word is whole.
  function automatic logic [31:0] keep_low_bytes(input logic [31:0] w,
                                                 input logic [1:0]  n);
    logic [31:0] r;
    case (n)
      2'd1:    r = w & 32'h0000_00FF;
      2'd2:    r = w & 32'h0000_FFFF;
      2'd3:    r = w & 32'h00FF_FFFF;
      default: r = w;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/msgseq_round_calc.sv
module msgseq_round_calc #(
  parameter int W    = 4,
  parameter int LENW = 12,
  localparam int NW  = $clog2(W + 1)
) (
  input  logic [LENW-1:0] rem,
  output logic [LENW-1:0] rbytes,
  output logic [NW-1:0]   nwords,
  output logic [1:0]      tail
);
  localparam int CAP = 4 * W;
  logic [LENW-1:0] rounded;

  always_comb begin
    rbytes  = (rem > LENW'(CAP)) ? LENW'(CAP) : rem;
    rounded = (rbytes + LENW'(3)) >> 2;
    nwords  = NW'(rounded);
    tail    = rbytes[1:0];
  end
endmodule

// File: rtl/msgseq_poll_guard.sv
module msgseq_poll_guard #(
  parameter int PLW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           hit,
  input  logic [PLW-1:0] limit,
  output logic           expire
);
  logic [PLW-1:0] cnt_q;
  logic [PLW-1:0] cnt_d;
  logic           cnt_en;
  logic [PLW:0]   cnt_inc;

  always_comb begin
    cnt_inc = {1'b0, cnt_q} + {{PLW{1'b0}}, 1'b1};
    expire  = hit && (cnt_inc >= {1'b0, limit});
    cnt_en  = clr || hit;
    cnt_d   = clr ? '0 : cnt_inc[PLW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/msg_window_seq.sv
module msg_window_seq #(
  parameter int W    = 4,
  parameter int BASE = 0,
  parameter int AW   = 7,
  parameter int LENW = 12,
  parameter int BAW  = 6,
  parameter int PLW  = 8,
  localparam int IW  = (W > 1) ? $clog2(W) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PLW-1:0]  cfg_poll_limit,
  input  logic            setup_start,
  input  logic            tx_start,
  input  logic [LENW-1:0] tx_len,
  input  logic            rx_start,
  output logic            busy,
  output logic            done,
  output logic            err,
  output logic [BAW-1:0]  buf_addr,
  input  logic [31:0]     buf_data,
  output logic            rx_we,
  output logic [IW-1:0]   rx_idx,
  output logic [31:0]     rx_data,
  output logic            bus_req,
  output logic            bus_we,
  output logic [2:0]      bus_reg,
  output logic [AW-1:0]   bus_win,
  output logic [31:0]     bus_wdata,
  input  logic            bus_ack,
  input  logic [31:0]     bus_rdata
);
  import msgseq_pkg::*;

  localparam int NW = $clog2(W + 1);
  localparam logic [AW-1:0] WIN_LO  = AW'(BASE);
  localparam logic [AW-1:0] WIN_TOP = AW'(BASE + W - 1);
  localparam logic [IW-1:0] IDX_TOP = IW'(W - 1);

  seq_state_e      state_q, state_d;
  logic [LENW-1:0] rem_q, rem_d;
  logic [BAW-1:0]  ptr_q, ptr_d;
  logic [IW-1:0]   widx_q, widx_d;
  logic            done_q, done_d;
  logic            err_q, err_d;
  logic            st_en;

  logic [LENW-1:0] rbytes;
  logic [NW-1:0]   nwords;
  logic [1:0]      tail;
  logic            poll_clr, poll_hit, poll_expire;
  logic [1:0]      keep_n;
  logic [31:0]     shaped;
  win_reg_e        reg_sel;

  msgseq_round_calc #(.W(W), .LENW(LENW)) round_i (
    .rem    (rem_q),
    .rbytes (rbytes),
    .nwords (nwords),
    .tail   (tail)
  );

  msgseq_poll_guard #(.PLW(PLW)) guard_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (poll_clr),
    .hit    (poll_hit),
    .limit  (cfg_poll_limit),
    .expire (poll_expire)
  );

  // The partial word is always the highest word of the round.
  always_comb begin
    keep_n = (NW'(widx_q) == nwords - NW'(1)) ? tail : 2'd0;
    shaped = keep_low_bytes(buf_data, keep_n);
  end

  always_comb begin
    state_d   = state_q;
    rem_d     = rem_q;
    ptr_d     = ptr_q;
    widx_d    = widx_q;
    done_d    = 1'b0;
    err_d     = 1'b0;
    poll_clr  = 1'b0;
    poll_hit  = 1'b0;
    bus_req   = 1'b0;
    bus_we    = 1'b0;
    reg_sel   = REG_STAT;
    bus_win   = WIN_LO;
    bus_wdata = '0;
    buf_addr  = ptr_q + BAW'(widx_q);
    rx_we     = 1'b0;
    rx_idx    = IDX_TOP - widx_q;
    rx_data   = bus_rdata;

    case (state_q)
      S_IDLE: begin
        widx_d = '0;
        if (setup_start) begin
          state_d = S_SETUP;
        end else if (tx_start) begin
          rem_d = tx_len;
          ptr_d = '0;
          if (tx_len == '0) done_d = 1'b1;
          else              state_d = S_TCHK;
        end else if (rx_start) begin
          state_d = S_RRD;
        end
      end

      S_SETUP: begin
        bus_req   = 1'b1;
        bus_we    = 1'b1;
        reg_sel   = (widx_q == IDX_TOP) ? REG_MCLR : REG_MSET;
        bus_win   = WIN_LO + AW'(widx_q);
        bus_wdata = '1;
        if (bus_ack) begin
          if (widx_q == IDX_TOP) begin
            state_d = S_IDLE;
            done_d  = 1'b1;
          end else begin
            widx_d = widx_q + IW'(1);
          end
        end
      end

      S_TCHK: begin
        buf_addr = ptr_q;
        if (keep_low_bytes(buf_data, (nwords == NW'(1)) ? tail : 2'd0) == '0) begin
          state_d = S_IDLE;
          done_d  = 1'b1;
          err_d   = 1'b1;
        end else begin
          state_d  = S_TPOLL;
          poll_clr = 1'b1;
        end
      end

      S_TPOLL: begin
        bus_req = 1'b1;
        bus_win = WIN_TOP;
        if (bus_ack) begin
          if (bus_rdata == '0) begin
            state_d = S_TWR;
            widx_d  = IW'(nwords - NW'(1));
          end else begin
            poll_hit = 1'b1;
            if (poll_expire) begin
              state_d = S_IDLE;
              done_d  = 1'b1;
              err_d   = 1'b1;
            end
          end
        end
      end

      S_TWR: begin
        bus_req   = 1'b1;
        bus_we    = 1'b1;
        reg_sel   = REG_SET;
        bus_win   = WIN_TOP - AW'(widx_q);
        bus_wdata = shaped;
        if (bus_ack) begin
          if (widx_q == '0) begin
            rem_d = rem_q - rbytes;
            ptr_d = ptr_q + BAW'(W);
            if (rem_q == rbytes) begin
              state_d = S_IDLE;
              done_d  = 1'b1;
            end else begin
              state_d = S_TCHK;
            end
          end else begin
            widx_d = widx_q - IW'(1);
          end
        end
      end

      S_RRD: begin
        bus_req = 1'b1;
        bus_win = WIN_LO + AW'(widx_q);
        rx_we   = bus_ack;
        if (bus_ack) state_d = S_RCLR;
      end

      S_RCLR: begin
        bus_req   = 1'b1;
        bus_we    = 1'b1;
        reg_sel   = REG_CLR;
        bus_win   = WIN_LO + AW'(widx_q);
        bus_wdata = '1;
        if (bus_ack) begin
          if (widx_q == IDX_TOP) begin
            state_d = S_IDLE;
            done_d  = 1'b1;
          end else begin
            widx_d  = widx_q + IW'(1);
            state_d = S_RRD;
          end
        end
      end

      default: state_d = S_IDLE;
    endcase

    bus_reg = reg_sel;
    st_en   = (state_d != state_q) || (widx_d != widx_q) || (rem_d != rem_q) || (ptr_d != ptr_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      rem_q   <= '0;
      ptr_q   <= '0;
      widx_q  <= '0;
    end else if (st_en) begin
      state_q <= state_d;
      rem_q   <= rem_d;
      ptr_q   <= ptr_d;
      widx_q  <= widx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  assign busy = (state_q != S_IDLE);
  assign done = done_q;
  assign err  = err_q;

endmodule

// File: rtl/msgseq_chk.sv
module msgseq_chk #(
  parameter int W    = 4,
  parameter int BASE = 0,
  parameter int AW   = 7,
  localparam int IW  = (W > 1) ? $clog2(W) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          err,
  input logic          rx_we,
  input logic [IW-1:0] rx_idx,
  input logic          bus_req,
  input logic          bus_we,
  input logic [2:0]    bus_reg,
  input logic [AW-1:0] bus_win,
  input logic [31:0]   bus_wdata,
  input logic          bus_ack
);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !bus_req);

  assert_window_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> (int'(bus_win) >= BASE) && (int'(bus_win) <= BASE + W - 1));

  assert_read_status_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_we) |-> (bus_reg == 3'd0));

  assert_clear_all_ones_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we && bus_reg == 3'd2) |-> (bus_wdata == 32'hFFFF_FFFF));

  assert_rx_on_read_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_we |-> (bus_req && bus_ack && !bus_we && int'(rx_idx) <= W - 1));

  assert_done_one_cycle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_err_with_done_R12: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);

  assert_end_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  assert_hold_until_ack_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_win) && $stable(bus_reg)
                               && $stable(bus_we) && $stable(bus_wdata)));

endmodule

bind msg_window_seq msgseq_chk #(.W(W), .BASE(BASE), .AW(AW)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .done      (done),
  .err       (err),
  .rx_we     (rx_we),
  .rx_idx    (rx_idx),
  .bus_req   (bus_req),
  .bus_we    (bus_we),
  .bus_reg   (bus_reg),
  .bus_win   (bus_win),
  .bus_wdata (bus_wdata),
  .bus_ack   (bus_ack)
);

// File: tb/msg_window_seq_tb_top.sv
module msg_window_seq_tb_top;
  localparam int W    = 4;
  localparam int BASE = 3;
  localparam int AW   = 7;
  localparam int LENW = 12;
  localparam int BAW  = 6;
  localparam int PLW  = 8;
  localparam int IW   = 2;
  localparam int TOP  = BASE + W - 1;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [PLW-1:0]  cfg_poll_limit = 8'd50;
  logic            setup_start = 1'b0;
  logic            tx_start = 1'b0;
  logic [LENW-1:0] tx_len = '0;
  logic            rx_start = 1'b0;
  logic            busy, done, err;
  logic [BAW-1:0]  buf_addr;
  logic [31:0]     buf_data;
  logic            rx_we;
  logic [IW-1:0]   rx_idx;
  logic [31:0]     rx_data;
  logic            bus_req, bus_we, bus_ack;
  logic [2:0]      bus_reg;
  logic [AW-1:0]   bus_win;
  logic [31:0]     bus_wdata, bus_rdata;

  always #10 clk = ~clk;

  msg_window_seq #(.W(W), .BASE(BASE), .AW(AW), .LENW(LENW), .BAW(BAW), .PLW(PLW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_poll_limit(cfg_poll_limit),
    .setup_start(setup_start), .tx_start(tx_start), .tx_len(tx_len), .rx_start(rx_start),
    .busy(busy), .done(done), .err(err),
    .buf_addr(buf_addr), .buf_data(buf_data),
    .rx_we(rx_we), .rx_idx(rx_idx), .rx_data(rx_data),
    .bus_req(bus_req), .bus_we(bus_we), .bus_reg(bus_reg), .bus_win(bus_win),
    .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata)
  );

  // Message buffer and bench-side window model
  logic [31:0] msg_buf [64];
  assign buf_data = msg_buf[buf_addr];

  logic [31:0] stat [W];
  logic [31:0] mask [W];
  logic [31:0] rx_out [W];
  int          ack_lat = 1;
  int          drain_delay = 3;
  int          drain_cnt;
  logic [3:0]  wait_cnt;
  int          log_n;
  int          log_win [512];
  logic [2:0]  log_reg [512];
  logic        log_we  [512];
  logic [31:0] log_dat [512];
  int          done_seen, err_seen;

  assign bus_ack = bus_req && (int'(wait_cnt) >= ack_lat);

  always_comb begin
    bus_rdata = '0;
    if (int'(bus_win) >= BASE && int'(bus_win) <= TOP) bus_rdata = stat[int'(bus_win) - BASE];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wait_cnt  <= '0;
      drain_cnt <= 0;
      log_n     <= 0;
      done_seen <= 0;
      err_seen  <= 0;
      for (int k = 0; k < W; k++) begin
        stat[k]   <= '0;
        mask[k]   <= '0;
        rx_out[k] <= '0;
      end
    end else begin
      wait_cnt <= (bus_req && !bus_ack) ? wait_cnt + 4'd1 : 4'd0;
      if (done) done_seen <= done_seen + 1;
      if (err)  err_seen  <= err_seen + 1;
      if (rx_we) rx_out[rx_idx] <= rx_data;
      if (drain_cnt == 1) for (int k = 0; k < W; k++) stat[k] <= '0;
      if (drain_cnt > 0) drain_cnt <= drain_cnt - 1;
      if (bus_req && bus_ack) begin
        log_win[log_n] <= int'(bus_win);
        log_reg[log_n] <= bus_reg;
        log_we[log_n]  <= bus_we;
        log_dat[log_n] <= bus_we ? bus_wdata : bus_rdata;
        log_n <= log_n + 1;
        if (bus_we && int'(bus_win) >= BASE && int'(bus_win) <= TOP) begin
          case (bus_reg)
            3'd1: begin
              stat[int'(bus_win) - BASE] <= stat[int'(bus_win) - BASE] | bus_wdata;
              if (int'(bus_win) == TOP && drain_delay != 0) drain_cnt <= drain_delay;
            end
            3'd2: stat[int'(bus_win) - BASE] <= stat[int'(bus_win) - BASE] & ~bus_wdata;
            3'd3: mask[int'(bus_win) - BASE] <= mask[int'(bus_win) - BASE] | bus_wdata;
            3'd4: mask[int'(bus_win) - BASE] <= mask[int'(bus_win) - BASE] & ~bus_wdata;
            default: ;
          endcase
        end
      end
    end
  end

  int n_pass = 0;
  int n_fail = 0;
  bit last_err;
  int log_base;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    if (ok) n_pass++;
    else begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Pulse one start (0 setup, 1 tx, 2 rx) and wait for the end pulse.
  task automatic run_op(input int kind, input int len);
    int n;
    log_base = log_n;
    @(negedge clk);
    tx_len = LENW'(len);
    setup_start = (kind == 0);
    tx_start    = (kind == 1);
    rx_start    = (kind == 2);
    n = 0;
    last_err = 1'b0;
    forever begin
      @(negedge clk);
      setup_start = 1'b0; tx_start = 1'b0; rx_start = 1'b0;
      if (done) begin last_err = err; break; end
      n++;
      if (n > 3000) begin
        check(1'b0, "R12", "operation never ended", 32'(n), 32'd0);
        break;
      end
    end
    repeat (12) @(negedge clk);
  endtask

  function automatic int count_writes(input int from);
    int c = 0;
    for (int k = from; k < log_n; k++) if (log_we[k]) c++;
    return c;
  endfunction

  function automatic int nth_write(input int from, input int nth);
    int c = 0;
    for (int k = from; k < log_n; k++)
      if (log_we[k]) begin
        if (c == nth) return k;
        c++;
      end
    return -1;
  endfunction

  task automatic expect_write(input int nth, input int win, input logic [2:0] rg,
                              input logic [31:0] dat, input string req);
    int k;
    k = nth_write(log_base, nth);
    if (k < 0) check(1'b0, req, "missing write", 32'(nth), 32'(win));
    else check(log_win[k] == win && log_reg[k] == rg && log_dat[k] == dat, req,
               $sformatf("write %0d win/reg/data", nth),
               {log_win[k][7:0], 5'd0, log_reg[k], log_dat[k][15:0]},
               {8'(win), 5'd0, rg, dat[15:0]});
  endtask

  task automatic t_reset;
    check(!busy && !done && !err && !bus_req, "R1", "idle after reset",
          {28'd0, busy, done, err, bus_req}, 32'd0);
  endtask

  task automatic t_setup;
    run_op(0, 0);
    check(count_writes(log_base) == W && log_n - log_base == W, "R10", "setup access count",
          32'(log_n - log_base), 32'(W));
    for (int i = 0; i < W - 1; i++) expect_write(i, BASE + i, 3'd3, 32'hFFFF_FFFF, "R10");
    expect_write(W - 1, TOP, 3'd4, 32'hFFFF_FFFF, "R10");
    check(mask[W-1] == 0 && mask[0] == 32'hFFFF_FFFF, "R10", "top unmasked only",
          mask[W-1], 32'd0);
  endtask

  task automatic t_two_rounds;
    int k5, nz;
    drain_delay = 3;
    run_op(1, 24);
    check(!last_err, "R8", "24-byte send ends clean", 32'(last_err), 32'd0);
    check(count_writes(log_base) == 6, "R3", "writes for 6 words", 32'(count_writes(log_base)), 32'd6);
    for (int i = 0; i < 4; i++) expect_write(i, TOP - (3 - i), 3'd1, msg_buf[3 - i], "R2");
    expect_write(4, TOP - 1, 3'd1, msg_buf[5], "R8");
    expect_write(5, TOP, 3'd1, msg_buf[4], "R2");
    k5 = nth_write(log_base, 4);
    check(k5 > 0 && !log_we[k5-1] && log_win[k5-1] == TOP && log_dat[k5-1] == 0, "R6",
          "zero status read just before round 2", k5 > 0 ? log_dat[k5-1] : 32'hDEAD, 32'd0);
    nz = 0;
    for (int k = log_base; k < log_n; k++) if (!log_we[k] && log_dat[k] != 0) nz++;
    check(nz >= 1, "R6", "waited on busy top window", 32'(nz), 32'd1);
  endtask

  task automatic t_partial;
    drain_delay = 3;
    run_op(1, 7);
    check(!last_err && count_writes(log_base) == 2, "R4", "7-byte send write count",
          32'(count_writes(log_base)), 32'd2);
    expect_write(0, TOP - 1, 3'd1, msg_buf[1] & 32'h00FF_FFFF, "R4");
    expect_write(1, TOP, 3'd1, msg_buf[0], "R2");
    msg_buf[0] = 32'h1234_0000;
    run_op(1, 2);
    check(last_err == 1'b1, "R5", "masked zero leading word refused", 32'(last_err), 32'd1);
    check(log_n == log_base, "R5", "no bus access on refusal", 32'(log_n - log_base), 32'd0);
    msg_buf[0] = 32'hABCD_1234;
    run_op(1, 2);
    check(!last_err && count_writes(log_base) == 1, "R3", "2-byte send one write",
          32'(count_writes(log_base)), 32'd1);
    expect_write(0, TOP, 3'd1, 32'h0000_1234, "R4");
  endtask

  task automatic t_zero_round;
    drain_delay = 3;
    msg_buf[4] = 32'd0;
    run_op(1, 24);
    check(last_err == 1'b1, "R5", "zero leading word of round 2", 32'(last_err), 32'd1);
    check(count_writes(log_base) == 4, "R5", "only round 1 written", 32'(count_writes(log_base)), 32'd4);
    msg_buf[4] = 32'h5555_0005;
  endtask

  task automatic t_zero_len;
    run_op(1, 0);
    check(!last_err && log_n == log_base, "R8", "zero length ends without bus",
          32'(log_n - log_base), 32'd0);
  endtask

  task automatic t_timeout;
    int lastw, nz;
    drain_delay = 0;
    cfg_poll_limit = 8'd5;
    run_op(1, 20);
    check(last_err == 1'b1, "R7", "poll timeout error", 32'(last_err), 32'd1);
    check(count_writes(log_base) == 4, "R7", "no write past busy window", 32'(count_writes(log_base)), 32'd4);
    lastw = nth_write(log_base, 3);
    nz = 0;
    for (int k = lastw + 1; k < log_n; k++) if (!log_we[k] && log_win[k] == TOP && log_dat[k] != 0) nz++;
    check(nz == 5 && log_n - lastw - 1 == 5, "R7", "busy reads before giving up", 32'(nz), 32'd5);
    cfg_poll_limit = 8'd50;
  endtask

  task automatic t_receive;
    run_op(2, 0);
    check(!last_err && log_n - log_base == 2 * W, "R9", "receive access count",
          32'(log_n - log_base), 32'(2 * W));
    for (int i = 0; i < W; i++) begin
      check(!log_we[log_base + 2*i] && log_win[log_base + 2*i] == BASE + i, "R9",
            $sformatf("read order %0d", i), 32'(log_win[log_base + 2*i]), 32'(BASE + i));
      check(log_we[log_base + 2*i + 1] && log_reg[log_base + 2*i + 1] == 3'd2 &&
            log_win[log_base + 2*i + 1] == BASE + i && log_dat[log_base + 2*i + 1] == 32'hFFFF_FFFF,
            "R9", $sformatf("clear after read %0d", i), log_dat[log_base + 2*i + 1], 32'hFFFF_FFFF);
    end
    for (int j = 0; j < W; j++)
      check(rx_out[j] == msg_buf[j], "R9", $sformatf("mirrored word %0d", j), rx_out[j], msg_buf[j]);
    check(stat[W-1] == 0 && stat[0] == 0, "R9", "windows cleared", stat[W-1], 32'd0);
  endtask

  task automatic t_busy_ignore;
    int d0, bad;
    drain_delay = 15;
    ack_lat = 2;
    d0 = done_seen;
    log_base = log_n;
    @(negedge clk); tx_len = 12'd24; tx_start = 1'b1;
    @(negedge clk); tx_start = 1'b0;
    repeat (6) @(negedge clk);
    setup_start = 1'b1; rx_start = 1'b1; tx_start = 1'b1; tx_len = 12'd4;
    @(negedge clk); setup_start = 1'b0; rx_start = 1'b0; tx_start = 1'b0;
    for (int n = 0; n < 3000 && busy; n++) @(negedge clk);
    repeat (40) @(negedge clk);
    check(done_seen - d0 == 1, "R11", "single end pulse", 32'(done_seen - d0), 32'd1);
    bad = 0;
    for (int k = log_base; k < log_n; k++) if (log_we[k] && log_reg[k] != 3'd1) bad++;
    check(bad == 0 && count_writes(log_base) == 6, "R11", "starts during transfer ignored",
          32'(count_writes(log_base)), 32'd6);
    expect_write(5, TOP, 3'd1, msg_buf[4], "R13");
    ack_lat = 1;
  endtask

  initial begin
    for (int k = 0; k < 64; k++) msg_buf[k] = 32'h1000_0000 + 32'(k * 17 + 1);
    msg_buf[1] = 32'hA1B2_C3D4;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_setup();
    t_two_rounds();
    t_partial();
    msg_buf[0] = 32'h1000_0001;
    t_zero_round();
    t_zero_len();
    repeat (20) @(negedge clk);
    t_timeout();
    t_receive();
    t_busy_ignore();
    check(err_seen <= done_seen, "R12", "err never without done", 32'(err_seen), 32'(done_seen));
    $display("%0d/%0d checks passed", n_pass, n_pass + n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL R12 watchdog expired: actual 1 expected 0");
    $display("%0d/%0d checks passed", n_pass, n_pass + n_fail + 1);
    $finish;
  end

endmodule